// File: doc/BRIEF.md
# Flag-Delimited Byte-Stuffed Frame Receiver

This block sits behind a serial byte source and pulls framed messages out of the incoming stream. Each frame is bounded by a flag byte. Inside a frame, an escape byte marks the next byte as transformed. The receiver undoes that transformation and keeps a running CRC-16 over the frame body. When the next flag arrives, it decides whether to keep the frame or drop it.

A kept frame is presented once as a header strobe that carries the command and length bytes. Its payload bytes then follow as a stream with first and last markers. A dropped frame leaves no trace on the outputs except an increment of a saturating drop counter. Causes of a drop are:
- a CRC failure;
- a length mismatch;
- an oversize frame;
- an abort sequence;
- the output still being busy with the previous frame.

The payload is held in two banks that are used alternately. This lets a new frame be received while the previous one is still being streamed out.

Top module: `frameRx`

## Requirements
- R1: After reset, all outputs are low and `dropCount` is 0. Bytes that arrive before the first flag (0x7E) are discarded, and they neither produce output nor count as drops.
- R2: The byte 0x7E delimits frames, and one flag may close one frame and open the next. An accepted frame raises `frameValid` for exactly one cycle, the cycle after its closing flag is sampled. At that time `frameCmd` holds the first body byte and `frameLen` holds the second.
- R3: Inside a frame, 0x7D is not data: the byte after it is taken as that byte XOR 0x20. So 0x7D 0x5E yields 0x7E, and 0x7D 0x5D yields 0x7D.
- R4: The last two body bytes are a CRC-16 over the command, length and payload bytes, most significant byte first. The CRC uses polynomial 0x1021, initial value 0xFFFF, no reflection and no final XOR. A frame whose CRC does not match is dropped, and `dropCount` rises by one.
- R5: A frame is accepted only if its unstuffed body holds at least 4 bytes and exactly the length field plus 4 bytes. Any other frame is dropped and counted.
- R6: An accepted frame with length L > 0 delivers L payload beats on `payValid` in consecutive cycles, starting the cycle after `frameValid`, in received order. The first beat carries `payFirst` and the last carries `payLast`. A frame with L = 0 delivers no beats.
- R7: Two adjacent flags form an empty frame, which is ignored without counting a drop.
- R8: 0x7D followed directly by 0x7E aborts the current frame, and the abort is counted as a drop. That flag then opens a fresh frame.
- R9: A frame whose length field exceeds `MaxPayload` is dropped and counted. A frame of exactly `MaxPayload` payload bytes is accepted.
- R10: A frame that would be accepted while payload beats of the previous frame are still due is dropped and counted. A frame whose closing flag arrives in the cycle after the last beat is issued is accepted.
- R11: `dropCount` rises by at most one per cycle and holds at all ones once it gets there.
- R12: A flag in the middle of a frame cuts that frame short, so the cut frame is judged and normally dropped. Decoding then restarts, and the next complete frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | `inByte` carries a received byte this cycle |
| inByte | input | 8 | Received stream byte |
| frameValid | output | 1 | One-cycle strobe announcing an accepted frame |
| frameCmd | output | 8 | Command byte of the announced frame |
| frameLen | output | 8 | Payload length of the announced frame |
| payValid | output | 1 | Payload beat valid |
| payData | output | 8 | Payload byte |
| payFirst | output | 1 | Beat is the first payload byte of its frame |
| payLast | output | 1 | Beat is the last payload byte of its frame |
| dropCount | output | CountW | Saturating count of dropped frames |

## Verification
The closing flag of a frame is sampled on some rising edge. `frameValid` and any change of `dropCount` appear just after that same edge. Payload beat k (counting from 0) appears k+1 cycles after the header strobe. The bench drives and samples on falling edges, so each result is read in the first half-cycle where it is due. The driver counts edges itself and uses that count to predict whether the output is still busy. It queues the expected header and payload items before they can appear, and the monitor pops and compares them in the cycle they show up. The drop counter is compared right after each closing flag.

// File: rtl/frameRxPkg.sv
`timescale 1ns/1ps
package frameRxPkg;

  localparam logic [7:0]  FlagByte = 8'h7E;
  localparam logic [7:0]  EscByte  = 8'h7D;
  localparam logic [7:0]  EscMask  = 8'h20;
  localparam logic [15:0] CrcInit  = 16'hFFFF;
  localparam logic [15:0] CrcPoly  = 16'h1021;

  // control -> datapath strobes
  typedef struct packed {
    logic       clear;   // flag seen: restart body accumulation
    logic       push;    // one unstuffed body byte in data
    logic [7:0] data;
    logic       accept;  // current body is kept and announced
    logic       beat;    // issue one payload beat
  } rxStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic frameOk;     // length and CRC checks both pass
    logic frameEmpty;  // no body byte since the last flag
    logic lenNonZero;  // length field of the body in progress is nonzero
    logic lastBeat;    // the beat about to be issued ends the payload
  } rxStatus_t;

  function automatic logic [15:0] crcStep(input logic [15:0] crcIn, input logic [7:0] d);
    logic [15:0] c;
    c = crcIn;
    for (int i = 7; i >= 0; i--) begin
      if (c[15] ^ d[i]) c = {c[14:0], 1'b0} ^ CrcPoly;
      else              c = {c[14:0], 1'b0};
    end
    return c;
  endfunction

endpackage

// File: rtl/frameRxCtrl.sv
`timescale 1ns/1ps
module frameRxCtrl
  import frameRxPkg::*;
#(
  parameter int CountW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [7:0]        inByte,
  input  rxStatus_t         status,
  output rxStrobe_t         strobe,
  output logic [CountW-1:0] dropCount
);

  localparam logic [CountW-1:0] CountMax = {CountW{1'b1}};

  logic inFrame, inFrameNext;
  logic escPend, escNext;
  logic busy;
  logic dropNow;

  always_comb begin
    strobe      = '0;
    strobe.data = escPend ? (inByte ^ EscMask) : inByte;
    strobe.beat = busy;
    dropNow     = 1'b0;
    escNext     = escPend;
    inFrameNext = inFrame;
    if (inValid) begin
      if (inByte == FlagByte) begin
        strobe.clear = 1'b1;
        escNext      = 1'b0;
        inFrameNext  = 1'b1;
        if (inFrame) begin
          if (escPend) begin
            dropNow = 1'b1;                       // abort sequence
          end else if (!status.frameEmpty) begin
            if (status.frameOk && !busy) strobe.accept = 1'b1;
            else                         dropNow       = 1'b1;
          end
        end
      end else if (inFrame) begin
        if (inByte == EscByte && !escPend) begin
          escNext = 1'b1;
        end else begin
          strobe.push = 1'b1;
          escNext     = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame   <= 1'b0;
      escPend   <= 1'b0;
      busy      <= 1'b0;
      dropCount <= '0;
    end else begin
      inFrame <= inFrameNext;
      escPend <= escNext;
      if (strobe.accept)                busy <= status.lenNonZero;
      else if (busy && status.lastBeat) busy <= 1'b0;
      if (dropNow && dropCount != CountMax) dropCount <= dropCount + 1'b1;
    end
  end

endmodule

// File: rtl/frameRxPath.sv
`timescale 1ns/1ps
module frameRxPath
  import frameRxPkg::*;
#(
  parameter int MaxPayload = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  rxStrobe_t  strobe,
  output rxStatus_t  status,
  output logic       frameValid,
  output logic [7:0] frameCmd,
  output logic [7:0] frameLen,
  output logic       payValid,
  output logic [7:0] payData,
  output logic       payFirst,
  output logic       payLast
);

  // payload plus the two CRC bytes land in the store
  localparam int StoreDepth = MaxPayload + 2;
  // saturation value of the byte count marks an oversize body
  localparam int CapCount   = MaxPayload + 5;
  localparam int CntW       = $clog2(CapCount + 1);
  localparam int IdxW       = $clog2(StoreDepth);

  logic [CntW-1:0] byteCnt;
  logic [15:0]     crcAcc;
  logic            wrBank, rdBank;
  logic [IdxW-1:0] rdIdx;
  logic            overflow, inStore;
  logic [IdxW-1:0] wrIdx;
  logic [7:0]      curLen;

  logic [7:0] bankCmd [2];
  logic [7:0] bankLen [2];
  logic [7:0] bankRd  [2];

  assign overflow = (byteCnt == CntW'(CapCount));
  assign inStore  = (int'(byteCnt) >= 2) && (int'(byteCnt) < 2 + StoreDepth);
  assign wrIdx    = IdxW'(int'(byteCnt) - 2);
  assign curLen   = bankLen[wrBank];

  always_comb begin
    status.frameOk    = (int'(byteCnt) >= 4) && (int'(byteCnt) == int'(curLen) + 4)
                        && !overflow && (crcAcc == 16'h0000);
    status.frameEmpty = (byteCnt == '0);
    status.lenNonZero = (curLen != 8'h00);
    status.lastBeat   = ({1'b0, frameLen} - 9'd1) == 9'(rdIdx);
  end

  for (genvar b = 0; b < 2; b++) begin : gBank
    logic [7:0] cmdReg, lenReg;
    logic [7:0] mem [StoreDepth];
    logic       wrSel;

    assign wrSel = strobe.push && (int'(wrBank) == b);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cmdReg <= '0;
        lenReg <= '0;
      end else if (wrSel) begin
        if (byteCnt == CntW'(0)) cmdReg <= strobe.data;
        if (byteCnt == CntW'(1)) lenReg <= strobe.data;
      end
    end

    always_ff @(posedge clk) begin
      if (wrSel && inStore) mem[wrIdx] <= strobe.data;
    end

    assign bankCmd[b] = cmdReg;
    assign bankLen[b] = lenReg;
    assign bankRd[b]  = mem[rdIdx];
  end

  // body accumulation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt <= '0;
      crcAcc  <= CrcInit;
    end else if (strobe.clear) begin
      byteCnt <= '0;
      crcAcc  <= CrcInit;
    end else if (strobe.push) begin
      crcAcc <= crcStep(crcAcc, strobe.data);
      if (!overflow) byteCnt <= byteCnt + CntW'(1);
    end
  end

  // announcement and payload replay
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameValid <= 1'b0;
      frameCmd   <= '0;
      frameLen   <= '0;
      payValid   <= 1'b0;
      payData    <= '0;
      payFirst   <= 1'b0;
      payLast    <= 1'b0;
      wrBank     <= 1'b0;
      rdBank     <= 1'b0;
      rdIdx      <= '0;
    end else begin
      frameValid <= 1'b0;
      payValid   <= 1'b0;
      payFirst   <= 1'b0;
      payLast    <= 1'b0;
      if (strobe.accept) begin
        frameValid <= 1'b1;
        frameCmd   <= bankCmd[wrBank];
        frameLen   <= curLen;
        rdBank     <= wrBank;
        wrBank     <= ~wrBank;
        rdIdx      <= '0;
      end else if (strobe.beat) begin
        payValid <= 1'b1;
        payData  <= bankRd[rdBank];
        payFirst <= (rdIdx == '0);
        payLast  <= status.lastBeat;
        rdIdx    <= rdIdx + IdxW'(1);
      end
    end
  end

endmodule

// File: rtl/frameRx.sv
`timescale 1ns/1ps
module frameRx
  import frameRxPkg::*;
#(
  parameter int MaxPayload = 32,
  parameter int CountW     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [7:0]        inByte,
  output logic              frameValid,
  output logic [7:0]        frameCmd,
  output logic [7:0]        frameLen,
  output logic              payValid,
  output logic [7:0]        payData,
  output logic              payFirst,
  output logic              payLast,
  output logic [CountW-1:0] dropCount
);

  rxStrobe_t strobe;
  rxStatus_t status;

  frameRxCtrl #(.CountW(CountW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inByte    (inByte),
    .status    (status),
    .strobe    (strobe),
    .dropCount (dropCount)
  );

  frameRxPath #(.MaxPayload(MaxPayload)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .status     (status),
    .frameValid (frameValid),
    .frameCmd   (frameCmd),
    .frameLen   (frameLen),
    .payValid   (payValid),
    .payData    (payData),
    .payFirst   (payFirst),
    .payLast    (payLast)
  );

endmodule

// File: rtl/frameRxChecker.sv
`timescale 1ns/1ps
module frameRxChecker #(
  parameter int CountW = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameValid,
  input logic [7:0]        frameLen,
  input logic              payValid,
  input logic              payFirst,
  input logic              payLast,
  input logic [CountW-1:0] dropCount
);

  assert_hdr_then_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && frameLen != 8'h00) |=> (payValid && payFirst));

  assert_zero_len_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && frameLen == 8'h00) |=> !payValid);

  assert_beats_contiguous_R6: assert property (@(posedge clk) disable iff (!rstN)
    (payValid && !payLast) |=> payValid);

  assert_last_ends_burst_R6: assert property (@(posedge clk) disable iff (!rstN)
    payLast |=> !payValid);

  assert_markers_on_beat_R6: assert property (@(posedge clk) disable iff (!rstN)
    (payFirst || payLast) |-> payValid);

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |-> !payValid);

  assert_drop_step_R11: assert property (@(posedge clk) disable iff (!rstN)
    (dropCount == $past(dropCount)) || (dropCount == $past(dropCount) + 1'b1));

  assert_drop_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(dropCount) == {CountW{1'b1}}) |-> (dropCount == {CountW{1'b1}}));

endmodule

bind frameRx frameRxChecker #(.CountW(CountW)) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .frameValid (frameValid),
  .frameLen   (frameLen),
  .payValid   (payValid),
  .payFirst   (payFirst),
  .payLast    (payLast),
  .dropCount  (dropCount)
);

// File: tb/frameRx_bench.sv
`timescale 1ns/1ps
module frameRx_bench;

  localparam int ClkPeriod = 10;
  localparam int MaxPay    = 32;
  localparam int CntWidth  = 8;
  localparam int DropMax   = (1 << CntWidth) - 1;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                inValid = 1'b0;
  logic [7:0]          inByte = 8'h00;
  logic                frameValid, payValid, payFirst, payLast;
  logic [7:0]          frameCmd, frameLen, payData;
  logic [CntWidth-1:0] dropCount;

  frameRx #(.MaxPayload(MaxPay), .CountW(CntWidth)) u_frameRx (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte),
    .frameValid(frameValid), .frameCmd(frameCmd), .frameLen(frameLen),
    .payValid(payValid), .payData(payData), .payFirst(payFirst),
    .payLast(payLast), .dropCount(dropCount)
  );

  always #(ClkPeriod/2) clk = ~clk;

  typedef struct {
    bit         isHdr;
    logic [7:0] a;      // cmd or data
    logic [7:0] b;      // len
    bit         first;
    bit         last;
  } expItem_t;

  expItem_t    expQ[$];
  byte unsigned body[$];
  int vectors = 0, misses = 0;
  int edgeCnt = 0, busyEnd = -1, expDrops = 0;
  bit finished = 0;

  function automatic logic [15:0] benchCrc(input int n);
    logic [15:0] r = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      r = r ^ {body[i], 8'h00};
      for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    end
    return r;
  endfunction

  task automatic step(input bit v, input logic [7:0] b);
    inValid = v;
    inByte  = b;
    @(posedge clk);
    edgeCnt++;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00);
  endtask

  task automatic bumpDrop();
    if (expDrops < DropMax) expDrops++;
  endtask

  // sends the closing flag and predicts the outcome of the collected body
  task automatic closeFrame();
    int  n;
    bit  ok;
    step(1'b1, 8'h7E);
    n = body.size();
    if (n != 0) begin
      ok = (n >= 4) && (n == int'(body[1]) + 4) && (int'(body[1]) <= MaxPay)
           && (benchCrc(n) == 16'h0000);
      if (ok && edgeCnt > busyEnd) begin
        expQ.push_back('{1'b1, body[0], body[1], 1'b0, 1'b0});
        for (int i = 0; i < int'(body[1]); i++)
          expQ.push_back('{1'b0, body[2+i], 8'h00, i == 0, i == int'(body[1]) - 1});
        busyEnd = edgeCnt + int'(body[1]);
      end else begin
        bumpDrop();
      end
    end
    body.delete();
  endtask

  task automatic sendBody();
    foreach (body[i]) begin
      if (body[i] == 8'h7E || body[i] == 8'h7D) begin
        step(1'b1, 8'h7D);
        step(1'b1, body[i] ^ 8'h20);
      end else begin
        step(1'b1, body[i]);
      end
    end
    closeFrame();
  endtask

  task automatic makeFrame(input logic [7:0] cmd, input logic [7:0] len,
                           input int nPay, input logic [7:0] seed, input bit badCrc);
    logic [15:0] c;
    body.delete();
    body.push_back(cmd);
    body.push_back(len);
    for (int i = 0; i < nPay; i++) body.push_back(8'(seed + 8'(i * 37)));
    c = benchCrc(body.size());
    if (badCrc) c = c ^ 16'h0001;
    body.push_back(c[15:8]);
    body.push_back(c[7:0]);
  endtask

  task automatic sealBody();
    logic [15:0] c;
    c = benchCrc(body.size());
    body.push_back(c[15:8]);
    body.push_back(c[7:0]);
  endtask

  task automatic checkDrops(input string tag);
    vectors++;
    if (int'(dropCount) != expDrops) begin
      misses++;
      $display("FAIL %s dropCount=%0d expected %0d", tag, dropCount, expDrops);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (frameValid) begin
        vectors++;
        if (expQ.size() == 0 || !expQ[0].isHdr) begin
          misses++;
          $display("FAIL R2 unexpected frameValid cmd=%h len=%0d expected no header", frameCmd, frameLen);
        end else begin
          if (frameCmd !== expQ[0].a || frameLen !== expQ[0].b) begin
            misses++;
            $display("FAIL R2 header cmd=%h len=%0d expected cmd=%h len=%0d",
                     frameCmd, frameLen, expQ[0].a, expQ[0].b);
          end
          void'(expQ.pop_front());
        end
      end
      if (payValid) begin
        vectors++;
        if (expQ.size() == 0 || expQ[0].isHdr) begin
          misses++;
          $display("FAIL R6 unexpected payload beat data=%h expected none", payData);
        end else begin
          if (payData !== expQ[0].a || payFirst !== expQ[0].first || payLast !== expQ[0].last) begin
            misses++;
            $display("FAIL R6 beat data=%h first=%b last=%b expected data=%h first=%b last=%b",
                     payData, payFirst, payLast, expQ[0].a, expQ[0].first, expQ[0].last);
          end
          void'(expQ.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(1);
    vectors++;
    if (frameValid !== 1'b0 || payValid !== 1'b0 || dropCount !== '0) begin
      misses++;
      $display("FAIL R1 reset outputs fv=%b pv=%b drops=%0d expected 0 0 0", frameValid, payValid, dropCount);
    end

    // R1: bytes before the first flag are ignored
    step(1'b1, 8'h11); step(1'b1, 8'h22); step(1'b1, 8'h7D); step(1'b1, 8'h33);
    step(1'b1, 8'h7E);
    idle(2);
    checkDrops("R1");

    // R2/R6: plain frame
    makeFrame(8'hA1, 8'd3, 3, 8'h10, 1'b0); sendBody(); idle(5);
    checkDrops("R2");

    // R3: escapes in command and payload
    body = '{8'h7E, 8'd4, 8'h7E, 8'h20, 8'h7D, 8'h5E}; sealBody(); sendBody(); idle(6);
    checkDrops("R3");

    // R6: zero-length frame
    makeFrame(8'h05, 8'd0, 0, 8'h00, 1'b0); sendBody(); idle(2);

    // R7: adjacent flags
    step(1'b1, 8'h7E); step(1'b1, 8'h7E); idle(1);
    checkDrops("R7");

    // R4: corrupted CRC
    makeFrame(8'h22, 8'd2, 2, 8'h40, 1'b1); sendBody(); idle(1);
    checkDrops("R4");

    // R5: length field too big, too small, body shorter than 4
    makeFrame(8'h31, 8'd5, 3, 8'h50, 1'b0); sendBody();
    makeFrame(8'h32, 8'd2, 3, 8'h60, 1'b0); sendBody();
    body = '{8'h01, 8'h00, 8'hFF}; sendBody(); idle(1);
    checkDrops("R5");

    // R8: abort then a good frame
    step(1'b1, 8'h09); step(1'b1, 8'h02); step(1'b1, 8'hAA); step(1'b1, 8'h7D);
    step(1'b1, 8'h7E); bumpDrop();
    checkDrops("R8");
    makeFrame(8'h0A, 8'd2, 2, 8'h7D, 1'b0); sendBody(); idle(4);
    checkDrops("R8");

    // R12: flag cuts a frame, next frame accepted
    makeFrame(8'h41, 8'd2, 2, 8'h01, 1'b0);
    void'(body.pop_back()); void'(body.pop_back());
    sendBody();
    makeFrame(8'h42, 8'd2, 2, 8'h03, 1'b0); sendBody(); idle(4);
    checkDrops("R12");

    // R9: oversize dropped, exact maximum accepted
    makeFrame(8'h51, 8'd40, 40, 8'h05, 1'b0); sendBody(); idle(1);
    checkDrops("R9");
    makeFrame(8'h52, 8'(MaxPay), MaxPay, 8'h07, 1'b0); sendBody(); idle(MaxPay + 3);
    checkDrops("R9");

    // R10: frame arriving while payload still streams is dropped
    makeFrame(8'h61, 8'd20, 20, 8'h11, 1'b0); sendBody();
    makeFrame(8'h62, 8'd0, 0, 8'h00, 1'b0); sendBody(); idle(1);
    checkDrops("R10");
    idle(22);
    // boundary: next closing flag lands just after the last beat
    makeFrame(8'h63, 8'd4, 4, 8'h21, 1'b0); sendBody();
    makeFrame(8'h64, 8'd0, 0, 8'h00, 1'b0); sendBody(); idle(6);
    checkDrops("R10");

    // R11: saturation of the drop counter
    step(1'b1, 8'h7E);
    for (int i = 0; i < 300; i++) begin
      step(1'b1, 8'h7D); step(1'b1, 8'h7E); bumpDrop();
    end
    idle(1);
    checkDrops("R11");

    idle(4);
    vectors++;
    if (expQ.size() != 0) begin
      misses++;
      $display("FAIL R6 outputs missing: %0d items pending expected 0", expQ.size());
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      misses++;
      $display("FAIL R2 watchdog expired after 200000 cycles expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule